// File: doc/BRIEF.md
# Operand Address Unit

This unit turns an addressing-mode code, two register specifiers and a 16-bit literal field into one source operand. On an accepted request it reads a base and an index register through a two-port combinational register-file read interface and forms an effective address. It fetches the operand through a single memory read port that uses a one-cycle request pulse and a later valid strobe. When the unit finishes it raises `done` for one cycle and presents the operand and the effective address.

Ten modes are handled. Register and immediate need no memory access. Register indirect, displacement, direct, indexed and scaled use one read. Memory indirect chains two reads. Autoincrement and autodecrement read once and also write a modified base register back through a register-file write port. A size code selects an operand size of 1, 2, 4 or 8 bytes. That size is the step for the auto-modifying modes and the multiplier for the scaled index. Data and addresses are `DW` bits wide, and the memory always returns one `DW`-bit word.

Top module: `opnd_addr_unit`

## Requirements
- R1: While reset is applied and in the first cycle after it, `done`, `busy`, `mem_req` and `rf_we` are low.
- R2: Mode code 0 (register), and the unused codes 10 to 15, give `operand` = value of the base register and `eff_addr` = 0. No memory read is issued, and `done` rises in the cycle after the request is accepted.
- R3: Mode code 1 (immediate) gives `operand` = the 16-bit field sign-extended to `DW` bits. No memory read is issued, and `done` rises in the cycle after acceptance.
- R4: Modes 2 (register indirect, address = base), 3 (displacement, base + sext(field)), 4 (direct, sext(field)) and 5 (indexed, base + index) each issue exactly one read at that address. `operand` is the returned word and `eff_addr` is the address.
- R5: Mode 9 (scaled) reads once at base + index * S + sext(field), where size codes 0, 1, 2 and 3 give S = 1, 2, 4 and 8.
- R6: Mode 6 (memory indirect) reads at the base value. It then reads at the returned word. `operand` is the second word and `eff_addr` is the second address.
- R7: Mode 7 (autoincrement) reads at base. In the `done` cycle it asserts `rf_we` with `rf_waddr` = base specifier and `rf_wdata` = base + S.
- R8: Mode 8 (autodecrement) reads at base - S. In the `done` cycle it writes base - S back to the base register. `rf_we` is never asserted for other modes.
- R9: `done` lasts exactly one cycle, and `busy` is low in the cycle after it.
- R10: A request presented while `busy` is high is ignored. The running operation completes with its own result, and no further `done` follows.
- R11: Each memory read is a one-cycle `mem_req` pulse issued while busy, with the address on `mem_addr`. The read completes on the first later cycle with `mem_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_mode | input | 4 | Addressing-mode code |
| req_size | input | 2 | Operand size code (1, 2, 4, 8 bytes) |
| req_base | input | RW | Base register specifier |
| req_index | input | RW | Index register specifier |
| req_field | input | 16 | Displacement or immediate field |
| busy | output | 1 | An operation is in progress |
| rf_raddr_a | output | RW | Register-file read address, base |
| rf_rdata_a | input | DW | Register-file read data, base |
| rf_raddr_b | output | RW | Register-file read address, index |
| rf_rdata_b | input | DW | Register-file read data, index |
| rf_we | output | 1 | Base register writeback strobe |
| rf_waddr | output | RW | Writeback register specifier |
| rf_wdata | output | DW | Writeback value |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | DW | Memory read address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |
| done | output | 1 | Operand ready strobe |
| operand | output | DW | Fetched operand, valid with done |
| eff_addr | output | DW | Effective address, valid with done |

## Verification
The hardest situation to reach is a second request that arrives while a slow chained read is in flight. The unit must hold its captured fields and must not start a new read or emit a second strobe. The bench reaches this by holding the request line high, with different mode and register fields, for the whole of a long-latency operation. It then checks that the result matches the first request and that no further strobe follows. Auto-modifying modes are swept repeatedly, so each later operation reads a base register that the unit itself has rewritten. Displacement and scaled sums are driven across the 32-bit wrap with negative fields.

// File: rtl/oau_pkg.sv
package oau_pkg;
  localparam logic [3:0] M_REG  = 4'd0;
  localparam logic [3:0] M_IMM  = 4'd1;
  localparam logic [3:0] M_RIND = 4'd2;
  localparam logic [3:0] M_DISP = 4'd3;
  localparam logic [3:0] M_DIR  = 4'd4;
  localparam logic [3:0] M_IDX  = 4'd5;
  localparam logic [3:0] M_MIND = 4'd6;
  localparam logic [3:0] M_AINC = 4'd7;
  localparam logic [3:0] M_ADEC = 4'd8;
  localparam logic [3:0] M_SCL  = 4'd9;

  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2, S_FIN
  } seq_st_e;

  // number of memory reads a mode needs
  function automatic logic [1:0] mem_reads(input logic [3:0] m);
    case (m)
      M_RIND, M_DISP, M_DIR, M_IDX, M_AINC, M_ADEC, M_SCL: mem_reads = 2'd1;
      M_MIND:                                              mem_reads = 2'd2;
      default:                                             mem_reads = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/oau_ea_calc.sv
module oau_ea_calc import oau_pkg::*; #(
  parameter int DW = 32
) (
  input  logic [3:0]    mode,
  input  logic [1:0]    size,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] idx,
  input  logic [15:0]   field,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] imm_val,
  output logic [DW-1:0] wb_val,
  output logic          wb_en
);
  function automatic logic [DW-1:0] sext16(input logic [15:0] f);
    sext16 = {{(DW-16){f[15]}}, f};
  endfunction

  function automatic logic [DW-1:0] step_of(input logic [1:0] s);
    step_of = DW'(1) << s;
  endfunction

  function automatic logic [DW-1:0] scaled(input logic [DW-1:0] v, input logic [1:0] s);
    scaled = v << s;
  endfunction

  logic [DW-1:0] disp, step;
  assign disp    = sext16(field);
  assign step    = step_of(size);
  assign imm_val = disp;

  always_comb begin
    case (mode)
      M_RIND, M_MIND, M_AINC: ea = base;
      M_DISP:                 ea = base + disp;
      M_DIR:                  ea = disp;
      M_IDX:                  ea = base + idx;
      M_ADEC:                 ea = base - step;
      M_SCL:                  ea = base + scaled(idx, size) + disp;
      default:                ea = '0;
    endcase
  end

  assign wb_en  = (mode == M_AINC) || (mode == M_ADEC);
  assign wb_val = (mode == M_ADEC) ? (base - step) : (base + step);
endmodule

// File: rtl/oau_seq.sv
module oau_seq import oau_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic needs_mem,
  input  logic two_step,
  input  logic mem_valid,
  output logic mem_req,
  output logic first_phase,
  output logic busy,
  output logic first_ret,
  output logic any_ret,
  output logic fin
);
  seq_st_e st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (start) st_nx = needs_mem ? S_RD1 : S_FIN;
      S_RD1:  st_nx = S_WT1;
      S_WT1:  if (mem_valid) st_nx = two_step ? S_RD2 : S_FIN;
      S_RD2:  st_nx = S_WT2;
      S_WT2:  if (mem_valid) st_nx = S_FIN;
      S_FIN:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  assign mem_req     = (st == S_RD1) || (st == S_RD2);
  assign first_phase = (st == S_RD1);
  assign busy        = (st != S_IDLE);
  assign first_ret   = (st == S_WT1) && mem_valid;
  assign any_ret     = first_ret || ((st == S_WT2) && mem_valid);
  assign fin         = (st == S_FIN);
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit import oau_pkg::*; #(
  parameter int DW = 32,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_mode,
  input  logic [1:0]    req_size,
  input  logic [RW-1:0] req_base,
  input  logic [RW-1:0] req_index,
  input  logic [15:0]   req_field,
  output logic          busy,
  output logic [RW-1:0] rf_raddr_a,
  input  logic [DW-1:0] rf_rdata_a,
  output logic [RW-1:0] rf_raddr_b,
  input  logic [DW-1:0] rf_rdata_b,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [DW-1:0] operand,
  output logic [DW-1:0] eff_addr
);
  // named internal events, used by the checker
  logic start_evt, ret_evt, first_ret, fin, rd1_phase;
  logic needs_mem, two_step;

  logic [3:0]    cap_mode;
  logic [1:0]    cap_size;
  logic [RW-1:0] cap_rb;
  logic [DW-1:0] cap_base, cap_idx;
  logic [15:0]   cap_field;
  logic [DW-1:0] ptr_q, data_q;
  logic [DW-1:0] ea, imm_val, wb_val;
  logic          wb_en;

  assign rf_raddr_a = req_base;
  assign rf_raddr_b = req_index;
  assign start_evt  = req_valid && !busy;
  assign needs_mem  = (mem_reads(req_mode) != 2'd0);
  assign two_step   = (mem_reads(cap_mode) == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_mode  <= M_REG;
      cap_size  <= '0;
      cap_rb    <= '0;
      cap_base  <= '0;
      cap_idx   <= '0;
      cap_field <= '0;
    end else if (start_evt) begin
      cap_mode  <= req_mode;
      cap_size  <= req_size;
      cap_rb    <= req_base;
      cap_base  <= rf_rdata_a;
      cap_idx   <= rf_rdata_b;
      cap_field <= req_field;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      data_q <= '0;
    end else begin
      if (ret_evt)   data_q <= mem_rdata;
      if (first_ret) ptr_q  <= mem_rdata;
    end
  end

  oau_ea_calc #(.DW(DW)) u_calc (
    .mode    (cap_mode),
    .size    (cap_size),
    .base    (cap_base),
    .idx     (cap_idx),
    .field   (cap_field),
    .ea      (ea),
    .imm_val (imm_val),
    .wb_val  (wb_val),
    .wb_en   (wb_en)
  );

  oau_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_evt),
    .needs_mem   (needs_mem),
    .two_step    (two_step),
    .mem_valid   (mem_valid),
    .mem_req     (mem_req),
    .first_phase (rd1_phase),
    .busy        (busy),
    .first_ret   (first_ret),
    .any_ret     (ret_evt),
    .fin         (fin)
  );

  assign mem_addr = rd1_phase ? ea : ptr_q;

  always_comb begin
    if (mem_reads(cap_mode) != 2'd0) operand = data_q;
    else if (cap_mode == M_IMM)      operand = imm_val;
    else                             operand = cap_base;
  end

  assign eff_addr = two_step ? ptr_q : ea;
  assign done     = fin;
  assign rf_we    = fin && wb_en;
  assign rf_waddr = cap_rb;
  assign rf_wdata = wb_val;
endmodule

// File: rtl/oau_check.sv
module oau_check (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic busy,
  input logic mem_req,
  input logic rf_we,
  input logic start_evt
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R11
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R11
  AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done); // R8
  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy); // R10
endmodule

bind opnd_addr_unit oau_check u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .busy      (busy),
  .mem_req   (mem_req),
  .rf_we     (rf_we),
  .start_evt (start_evt)
);

// File: tb/opnd_addr_unit_test.sv
module opnd_addr_unit_test;
  localparam int DW = 32;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [3:0]    req_mode = '0;
  logic [1:0]    req_size = '0;
  logic [RW-1:0] req_base = '0, req_index = '0;
  logic [15:0]   req_field = '0;
  logic          busy, rf_we, mem_req, done;
  logic [RW-1:0] rf_raddr_a, rf_raddr_b, rf_waddr;
  logic [DW-1:0] rf_rdata_a, rf_rdata_b, rf_wdata, mem_addr, operand, eff_addr;
  logic          mem_valid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  opnd_addr_unit #(.DW(DW), .RW(RW)) uut (.*);

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int rd_cnt = 0;

  // register file model
  logic [DW-1:0] regs [8];
  logic          ld_en = 1'b0;
  logic [RW-1:0] ld_idx = '0;
  logic [DW-1:0] ld_val = '0;
  assign rf_rdata_a = regs[rf_raddr_a];
  assign rf_rdata_b = regs[rf_raddr_b];
  always @(posedge clk) begin
    if (ld_en) regs[ld_idx] <= ld_val;
    else if (rf_we) regs[rf_waddr] <= rf_wdata;
  end

  function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
    memf = {a[15:0], ~a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  // memory model: response lat+1 cycles after the request edge
  logic pend = 1'b0;
  logic [DW-1:0] paddr = '0;
  int wcnt = 0;
  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mem_req) begin
      rd_cnt = rd_cnt + 1;
      pend  <= 1'b1;
      paddr <= mem_addr;
      wcnt  <= lat;
    end else if (pend) begin
      if (wcnt == 0) begin
        mem_valid <= 1'b1;
        mem_rdata <= memf(paddr);
        pend <= 1'b0;
      end else wcnt <= wcnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_reg(input int i, input logic [DW-1:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = RW'(i); ld_val = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // one operation; hold=1 keeps a conflicting request up while busy
  task automatic run(input logic [3:0] m, input logic [1:0] s, input int b, input int x,
                     input logic [15:0] f, input bit hold);
    logic [DW-1:0] bv, xv, dv, sc, ea_e, op_e, wb_e, p;
    int reads_e, rd0, cyc;
    bit wb_e_en, seen;
    string tg;
    @(negedge clk);
    bv = regs[b]; xv = regs[x];
    dv = {{16{f[15]}}, f};
    sc = 32'd1 << s;
    wb_e_en = 1'b0; wb_e = '0; reads_e = 1; ea_e = '0; op_e = '0;
    case (m)
      4'd1: begin reads_e = 0; op_e = dv; tg = "R3"; end
      4'd2: begin ea_e = bv; tg = "R4"; end
      4'd3: begin ea_e = bv + dv; tg = "R4"; end
      4'd4: begin ea_e = dv; tg = "R4"; end
      4'd5: begin ea_e = bv + xv; tg = "R4"; end
      4'd6: begin p = memf(bv); ea_e = p; reads_e = 2; tg = "R6"; end
      4'd7: begin ea_e = bv; wb_e_en = 1'b1; wb_e = bv + sc; tg = "R7"; end
      4'd8: begin ea_e = bv - sc; wb_e_en = 1'b1; wb_e = bv - sc; tg = "R8"; end
      4'd9: begin ea_e = bv + xv * sc + dv; tg = "R5"; end
      default: begin reads_e = 0; op_e = bv; tg = "R2"; end
    endcase
    if (reads_e != 0) op_e = memf(ea_e);
    if (hold) tg = "R10";
    req_valid = 1'b1; req_mode = m; req_size = s;
    req_base = RW'(b); req_index = RW'(x); req_field = f;
    rd0 = rd_cnt;
    cyc = 0; seen = 1'b0;
    while (!seen && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (hold) begin
        req_mode = 4'd0; req_base = RW'(x); req_field = ~f;
      end else req_valid = 1'b0;
      seen = done;
    end
    req_valid = 1'b0;
    if (!seen) begin
      chk(1'b0, {tg, " done never rose"}, 0, 1);
      return;
    end
    chk(operand == op_e, {tg, " operand"}, operand, op_e);
    chk(eff_addr == ea_e, {tg, " eff_addr"}, eff_addr, ea_e);
    chk((rd_cnt - rd0) == reads_e, {tg, " R11 read count"}, DW'(rd_cnt - rd0), DW'(reads_e));
    chk(rf_we == wb_e_en, {tg, " R8 rf_we"}, DW'(rf_we), DW'(wb_e_en));
    if (wb_e_en) begin
      chk(rf_waddr == RW'(b), {tg, " rf_waddr"}, DW'(rf_waddr), DW'(b));
      chk(rf_wdata == wb_e, {tg, " rf_wdata"}, rf_wdata, wb_e);
    end
    if (reads_e == 0) chk(cyc == 1, {tg, " done latency"}, DW'(cyc), 1);
    @(negedge clk);
    chk(!done && !busy, "R9 done single cycle then idle", DW'({done, busy}), 0);
    if (hold) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!done && !busy, "R10 no extra done after held request", DW'({done, busy}), 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_req && !rf_we, "R1 outputs in reset", DW'({done, busy, mem_req, rf_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !mem_req && !rf_we, "R1 outputs after reset", DW'({done, busy, mem_req, rf_we}), 0);
    for (int i = 0; i < 8; i++)
      load_reg(i, 32'h0010_2000 * (i + 1) + 32'h31 * i);
    load_reg(7, 32'hFFFF_FFF4);
    for (int m = 0; m < 12; m++)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 2; v++) begin
          lat = (m + s + v) % 3;
          if (v == 0) run(4'(m), 2'(s), 1, 2, 16'h0010, 1'b0);
          else        run(4'(m), 2'(s), 7, 5, 16'hFFF8, 1'b0);
        end
    run(4'd15, 2'd0, 3, 0, 16'h1234, 1'b0);     // R2 reserved code
    run(4'd9, 2'd3, 7, 7, 16'h8000, 1'b0);      // R5 wrap with large negative field
    lat = 3;
    run(4'd6, 2'd1, 4, 1, 16'h0000, 1'b1);      // R10 held request during chained reads
    run(4'd3, 2'd2, 2, 3, 16'h7FFF, 1'b1);      // R10 held request during single read
    lat = 0;
    run(4'd0, 2'd0, 6, 1, 16'h0000, 1'b1);      // R10 held request on register mode
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule